// File: doc/BRIEF.md
# Interrupt Aggregator with Grouped Outputs

This block gathers a parameterised number of level-sensitive interrupt lines (a multiple of 32, up to 512) into a few summary interrupts. The inputs are split into 32-bit words. Each word has an enable mask and a software-set register. The block reports the resulting pending status for each word. Every run of 64 inputs drives one registered output interrupt. When the word count is odd, the last output covers a single word.

Software reaches the block through a flat 32-bit register port: a byte offset, a write strobe, write data and combinational read data. The register map holds the following:
- a channel-select register at offset 0
- three banks (mask, set and status), each with one entry per word
- a per-output disable register
- an ungated per-output summary register

Inside every bank the words are stored high to low. The entry at the lowest address holds the highest-numbered inputs. The base of each bank moves with the word count. A host saves the mask bank and channel register by reading them, and restores them by writing the same values back.

Top module: `irq_aggregator`

## Requirements
- R1: With N inputs there are W = N/32 words and N_OUT = ceil(N/64) outputs; the default build has N = 160, so W = 5 and N_OUT = 3.
- R2: The channel register is at offset 0x0 and reads back what was written (its low N_CHAN bits). While it holds zero, every output stays low.
- R3: Mask entry j is at offset 4 + 4*j and reads back as written. A mask bit of 1 enables its input, and a bit of 0 blocks it.
- R4: Input i is located in word index W-1-floor(i/32), at bit i mod 32, in every bank.
- R5: Set entry j is at offset 4*W + 4 + 4*j. A set bit counts as pending in exactly the way an active input does.
- R6: Status entry j is at offset 8*W + 4 + 4*j and reads (input | set) & mask for that word. Writes to the status bank change no register.
- R7: Output k is high one clock after any enabled pending source among inputs 64k..64k+63. With an odd W, the last output covers only inputs 64k..64k+31.
- R8: Disable register at offset 12*W + 4: while bit k is set, output k is held low. The summary register at offset 12*W + 8 reads the ungated pending OR of group k in bit k.
- R9: A synchronous, active-high reset clears every register and output to zero.
- R10: A read from an unmapped or unaligned offset returns zero. A write to such an offset changes no register.
- R11: Outputs are levels: an output stays high while its enabled source remains active, and falls one clock after the source is removed.
- R12: Rewriting the saved channel value and saved mask words after a reset restores the previous output behaviour and mask contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 12 | Register byte offset |
| wr_en | input | 1 | Write strobe for the addressed register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, combinational |
| irq_in | input | N_IN | Level-sensitive interrupt inputs |
| irq_out | output | N_OUT | Registered grouped interrupt outputs |

## Verification
The following rules are checked by the assertions on every clock, whatever the traffic:
- an output never rises while the channel register is zero, while its disable bit is set, or without a pending source in its group
- status-bank and unmapped writes leave every register unchanged
- unmapped reads return zero and the summary read matches the group ORs
- reset leaves the registers cleared

The remaining behaviour only shows up in the bench's scenarios: the reversed word placement of each input, the boundaries between groups including the single-word last group, the one-cycle output latency, the set path, and the save-and-restore sequence.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

    localparam int OFF_W      = 12;
    localparam int IDX_W      = 5;
    localparam int WORD_BITS  = 32;
    localparam int GROUP_BITS = 64;
    localparam int MAX_INPUTS = 512;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_CHAN,
        RK_MASK,
        RK_SET,
        RK_STAT,
        RK_MDIS,
        RK_MSTAT
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e        kind;
        logic [IDX_W-1:0] idx;
    } reg_sel_t;

    // Translate a byte offset into a register kind and bank index.
    // The bank bases scale with the word count.
    function automatic reg_sel_t decode_offset(input logic [OFF_W-1:0] off,
                                               input int unsigned words);
        reg_sel_t    s;
        int unsigned o;
        int unsigned span;
        s.kind = RK_NONE;
        s.idx  = '0;
        o      = {20'd0, off};
        span   = 4 * words;
        if (off[1:0] == 2'b00) begin
            if (o == 0) begin
                s.kind = RK_CHAN;
            end else if (o < span + 4) begin
                s.kind = RK_MASK;
                s.idx  = IDX_W'((o - 4) >> 2);
            end else if (o < 2 * span + 4) begin
                s.kind = RK_SET;
                s.idx  = IDX_W'((o - 4 - span) >> 2);
            end else if (o < 3 * span + 4) begin
                s.kind = RK_STAT;
                s.idx  = IDX_W'((o - 4 - 2 * span) >> 2);
            end else if (o == 3 * span + 4) begin
                s.kind = RK_MDIS;
            end else if (o == 3 * span + 8) begin
                s.kind = RK_MSTAT;
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/irqagg_regs.sv
module irqagg_regs
    import irqagg_pkg::*;
#(
    parameter int WORDS  = 5,
    parameter int N_OUT  = 3,
    parameter int N_CHAN = 8
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  reg_sel_t                       sel,
    input  logic [WORD_BITS-1:0]           wdata,
    output logic [N_CHAN-1:0]              chan_q,
    output logic [WORDS-1:0][WORD_BITS-1:0] mask_q,
    output logic [WORDS-1:0][WORD_BITS-1:0] set_q,
    output logic [N_OUT-1:0]               mdis_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            chan_q <= '0;
        end else if (wr_en && sel.kind == RK_CHAN) begin
            chan_q <= wdata[N_CHAN-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mdis_q <= '0;
        end else if (wr_en && sel.kind == RK_MDIS) begin
            mdis_q <= wdata[N_OUT-1:0];
        end
    end

    for (genvar j = 0; j < WORDS; j++) begin : g_word
        logic                 hit;
        logic [WORD_BITS-1:0] m_q;
        logic [WORD_BITS-1:0] s_q;

        assign hit = wr_en && (sel.idx == IDX_W'(j));

        always_ff @(posedge clk) begin
            if (rst) begin
                m_q <= '0;
                s_q <= '0;
            end else begin
                if (hit && sel.kind == RK_MASK) begin
                    m_q <= wdata;
                end
                if (hit && sel.kind == RK_SET) begin
                    s_q <= wdata;
                end
            end
        end

        assign mask_q[j] = m_q;
        assign set_q[j]  = s_q;
    end

endmodule

// File: rtl/irqagg_group.sv
module irqagg_group
    import irqagg_pkg::*;
#(
    parameter int N_IN  = 160,
    parameter int WORDS = 5,
    parameter int N_OUT = 3
) (
    input  logic [N_IN-1:0]                irq_in,
    input  logic [WORDS-1:0][WORD_BITS-1:0] mask_q,
    input  logic [WORDS-1:0][WORD_BITS-1:0] set_q,
    output logic [WORDS-1:0][WORD_BITS-1:0] status,
    output logic [N_OUT-1:0]               grp_or
);

    // Word j holds inputs (WORDS-1-j)*32 .. +31: lowest inputs sit in the top word.
    for (genvar j = 0; j < WORDS; j++) begin : g_stat
        localparam int BASE = (WORDS - 1 - j) * WORD_BITS;
        assign status[j] = (irq_in[BASE +: WORD_BITS] | set_q[j]) & mask_q[j];
    end

    for (genvar k = 0; k < N_OUT; k++) begin : g_out
        localparam int LO_WORD = WORDS - 1 - 2 * k;
        if (2 * k + 1 < WORDS) begin : g_pair
            assign grp_or[k] = (|status[LO_WORD]) | (|status[LO_WORD-1]);
        end else begin : g_single
            assign grp_or[k] = |status[LO_WORD];
        end
    end

endmodule

// File: rtl/irqagg_rdmux.sv
module irqagg_rdmux
    import irqagg_pkg::*;
#(
    parameter int WORDS  = 5,
    parameter int N_OUT  = 3,
    parameter int N_CHAN = 8
) (
    input  reg_sel_t                       sel,
    input  logic [N_CHAN-1:0]              chan_q,
    input  logic [WORDS-1:0][WORD_BITS-1:0] mask_q,
    input  logic [WORDS-1:0][WORD_BITS-1:0] set_q,
    input  logic [WORDS-1:0][WORD_BITS-1:0] status,
    input  logic [N_OUT-1:0]               mdis_q,
    input  logic [N_OUT-1:0]               grp_or,
    output logic [WORD_BITS-1:0]           rd_data
);

    always_comb begin
        rd_data = '0;
        case (sel.kind)
            RK_CHAN:  rd_data[N_CHAN-1:0] = chan_q;
            RK_MASK, RK_SET, RK_STAT: begin
                for (int j = 0; j < WORDS; j++) begin
                    if (sel.idx == IDX_W'(j)) begin
                        if (sel.kind == RK_MASK)     rd_data = mask_q[j];
                        else if (sel.kind == RK_SET) rd_data = set_q[j];
                        else                         rd_data = status[j];
                    end
                end
            end
            RK_MDIS:  rd_data[N_OUT-1:0] = mdis_q;
            RK_MSTAT: rd_data[N_OUT-1:0] = grp_or;
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irqagg_pkg::*;
#(
    parameter  int N_IN   = 160,
    parameter  int N_CHAN = 8,
    localparam int WORDS  = N_IN / WORD_BITS,
    localparam int N_OUT  = (N_IN + GROUP_BITS - 1) / GROUP_BITS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [OFF_W-1:0]     addr,
    input  logic                 wr_en,
    input  logic [WORD_BITS-1:0] wr_data,
    output logic [WORD_BITS-1:0] rd_data,
    input  logic [N_IN-1:0]      irq_in,
    output logic [N_OUT-1:0]     irq_out
);

    reg_sel_t                        sel;
    logic [N_CHAN-1:0]               chan_q;
    logic [WORDS-1:0][WORD_BITS-1:0] mask_q;
    logic [WORDS-1:0][WORD_BITS-1:0] set_q;
    logic [WORDS-1:0][WORD_BITS-1:0] status;
    logic [N_OUT-1:0]                mdis_q;
    logic [N_OUT-1:0]                grp_or;
    logic [N_OUT-1:0]                out_q;

    assign sel = decode_offset(addr, WORDS);

    irqagg_regs #(.WORDS(WORDS), .N_OUT(N_OUT), .N_CHAN(N_CHAN)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .sel    (sel),
        .wdata  (wr_data),
        .chan_q (chan_q),
        .mask_q (mask_q),
        .set_q  (set_q),
        .mdis_q (mdis_q)
    );

    irqagg_group #(.N_IN(N_IN), .WORDS(WORDS), .N_OUT(N_OUT)) u_group (
        .irq_in (irq_in),
        .mask_q (mask_q),
        .set_q  (set_q),
        .status (status),
        .grp_or (grp_or)
    );

    irqagg_rdmux #(.WORDS(WORDS), .N_OUT(N_OUT), .N_CHAN(N_CHAN)) u_rdmux (
        .sel     (sel),
        .chan_q  (chan_q),
        .mask_q  (mask_q),
        .set_q   (set_q),
        .status  (status),
        .mdis_q  (mdis_q),
        .grp_or  (grp_or),
        .rd_data (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q <= grp_or & ~mdis_q & {N_OUT{|chan_q}};
        end
    end

    assign irq_out = out_q;

endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk
    import irqagg_pkg::*;
#(
    parameter int WORDS  = 5,
    parameter int N_OUT  = 3,
    parameter int N_CHAN = 8
) (
    input logic                            clk,
    input logic                            rst,
    input logic [OFF_W-1:0]                addr,
    input logic                            wr_en,
    input logic [WORD_BITS-1:0]            rd_data,
    input logic [N_OUT-1:0]                irq_out,
    input logic [N_CHAN-1:0]               chan_q,
    input logic [WORDS-1:0][WORD_BITS-1:0] mask_q,
    input logic [WORDS-1:0][WORD_BITS-1:0] set_q,
    input logic [N_OUT-1:0]                mdis_q,
    input logic [N_OUT-1:0]                grp_or
);

    localparam int STAT_LO = 8 * WORDS + 4;
    localparam int STAT_HI = 12 * WORDS + 4;
    localparam int MSTAT   = 12 * WORDS + 8;

    logic in_stat;
    logic unmapped;
    logic is_mstat;

    always_comb begin
        in_stat  = (addr[1:0] == 2'b00) && (int'(addr) >= STAT_LO) && (int'(addr) < STAT_HI);
        unmapped = (addr[1:0] != 2'b00) || (int'(addr) > MSTAT);
        is_mstat = (int'(addr) == MSTAT);
    end

    // R2: no output while no channel is selected
    a_r2_chan_zero_quiet: assert property (@(posedge clk) disable iff (rst)
        (chan_q == '0) |=> (irq_out == '0));

    // R8: a disabled output stays low
    a_r8_disable_forces_low: assert property (@(posedge clk) disable iff (rst)
        (mdis_q != '0) |=> ((irq_out & $past(mdis_q)) == '0));

    // R8: summary register reflects the group ORs
    a_r8_summary_read: assert property (@(posedge clk) disable iff (rst)
        is_mstat |-> (rd_data == WORD_BITS'(grp_or)));

    // R7: an output only rises for a pending group
    a_r7_out_within_group: assert property (@(posedge clk) disable iff (rst)
        (irq_out != '0) |-> ((irq_out & ~$past(grp_or)) == '0));

    // R6: status writes are discarded
    a_r6_status_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_en && in_stat) |=> ($stable(mask_q) && $stable(set_q) && $stable(chan_q) && $stable(mdis_q)));

    // R10: unmapped reads are zero
    a_r10_unmapped_read_zero: assert property (@(posedge clk) disable iff (rst)
        unmapped |-> (rd_data == '0));

    // R10: unmapped writes are discarded
    a_r10_unmapped_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_en && unmapped) |=> ($stable(mask_q) && $stable(set_q) && $stable(chan_q) && $stable(mdis_q)));

    // R9: reset clears the registers
    a_r9_reset_clears: assert property (@(posedge clk)
        rst |=> (mask_q == '0 && set_q == '0 && chan_q == '0 && mdis_q == '0 && irq_out == '0));

endmodule

bind irq_aggregator irq_aggregator_chk #(.WORDS(WORDS), .N_OUT(N_OUT), .N_CHAN(N_CHAN)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .addr    (addr),
    .wr_en   (wr_en),
    .rd_data (rd_data),
    .irq_out (irq_out),
    .chan_q  (chan_q),
    .mask_q  (mask_q),
    .set_q   (set_q),
    .mdis_q  (mdis_q),
    .grp_or  (grp_or)
);

// File: tb/irq_aggregator_bench.sv
module irq_aggregator_bench;

    localparam int N_IN  = 160;
    localparam int W     = N_IN / 32;
    localparam int N_OUT = 3;
    localparam int A_SET  = 4 * W + 4;
    localparam int A_STAT = 8 * W + 4;
    localparam int A_MDIS = 12 * W + 4;
    localparam int A_MST  = 12 * W + 8;

    typedef struct packed {
        logic [7:0] src;
        logic       en;
        logic [2:0] exp_out;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{8'd0,   1'b1, 3'b001},
        '{8'd31,  1'b1, 3'b001},
        '{8'd63,  1'b1, 3'b001},
        '{8'd64,  1'b1, 3'b010},
        '{8'd127, 1'b1, 3'b010},
        '{8'd128, 1'b1, 3'b100},
        '{8'd159, 1'b1, 3'b100},
        '{8'd5,   1'b0, 3'b000},
        '{8'd100, 1'b0, 3'b000},
        '{8'd140, 1'b0, 3'b000}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [11:0]       addr = '0;
    logic              wr_en = 1'b0;
    logic [31:0]       wr_data = '0;
    logic [31:0]       rd_data;
    logic [N_IN-1:0]   irq_in = '0;
    logic [N_OUT-1:0]  irq_out;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] saved [W];
    logic [31:0] saved_chan;

    always #4ns clk = ~clk;

    irq_aggregator #(.N_IN(N_IN), .N_CHAN(8)) u_irq_aggregator (
        .clk     (clk),
        .rst     (rst),
        .addr    (addr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .irq_in  (irq_in),
        .irq_out (irq_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        addr = 12'(a);
        wr_data = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        addr = 12'(a);
        #1ns;
        d = rd_data;
    endtask

    function automatic int word_of(input int i);
        return W - 1 - i / 32;
    endfunction

    initial begin : watchdog
        #(8ns * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        tick(3);
        rst = 1'b0;
        tick(1);

        // R9 reset state
        chk("R9 out", 32'(irq_out), 0);
        rd(0, d);      chk("R9 chan", d, 0);
        rd(4, d);      chk("R9 mask0", d, 0);
        rd(A_MDIS, d); chk("R9 mdis", d, 0);
        // R1 output count
        chk("R1 width", $bits(irq_out), 3);

        // R2: masks on, input on, channel zero -> quiet
        for (int j = 0; j < W; j++) wr(4 + 4 * j, 32'hFFFF_FFFF);
        irq_in[0] = 1'b1;
        tick(2);
        chk("R2 chan zero", 32'(irq_out), 0);
        wr(0, 32'h0000_0001);
        rd(0, d); chk("R2 chan readback", d, 1);
        tick(2);
        chk("R2 chan set", 32'(irq_out), 1);
        // R3 mask readback
        rd(4 + 4 * 2, d); chk("R3 mask readback", d, 32'hFFFF_FFFF);

        // Table walk: R4, R7, R3, R6
        for (int r = 0; r < 10; r++) begin
            int src;
            src = int'(VECS[r].src);
            for (int j = 0; j < W; j++) wr(4 + 4 * j, 32'h0);
            irq_in = '0;
            irq_in[src] = 1'b1;
            if (VECS[r].en) wr(4 + 4 * word_of(src), 32'h1 << (src % 32));
            tick(2);
            chk($sformatf("R7 row %0d out", r), 32'(irq_out), 32'(VECS[r].exp_out));
            rd(A_STAT + 4 * word_of(src), d);
            chk($sformatf("R4 row %0d status", r), d,
                VECS[r].en ? (32'h1 << (src % 32)) : 32'h0);
        end

        // R7 output latency: one clock after the source
        for (int j = 0; j < W; j++) wr(4 + 4 * j, 32'h0);
        irq_in = '0;
        wr(4 + 4 * 1, 32'h0000_8000); // input 111 -> word 1 bit 15
        tick(1);
        irq_in[111] = 1'b1;
        #1ns;
        chk("R7 before edge", 32'(irq_out), 0);
        tick(1);
        chk("R7 one clock", 32'(irq_out), 32'b010);
        irq_in = '0;

        // R5 set path
        wr(4 + 4 * 4, 32'h0000_0008);
        wr(A_SET + 4 * 4, 32'h0000_0008);
        wr(A_SET + 4 * 0, 32'h0000_0001); // input 128, masked off
        tick(2);
        chk("R5 set raises", 32'(irq_out), 32'b001);
        rd(A_STAT + 4 * 4, d); chk("R5 status", d, 32'h8);
        rd(A_SET + 4 * 0, d);  chk("R5 set readback", d, 32'h1);

        // R6 status write ignored
        wr(A_STAT + 4 * 4, 32'h0);
        rd(A_STAT + 4 * 4, d); chk("R6 status kept", d, 32'h8);
        rd(4 + 4 * 4, d);      chk("R6 mask kept", d, 32'h8);

        // R8 master disable and summary
        wr(A_MDIS, 32'h1);
        tick(2);
        chk("R8 disabled", 32'(irq_out), 0);
        rd(A_MST, d); chk("R8 summary", d, 32'h1);
        wr(A_MDIS, 32'h0);
        tick(2);
        chk("R8 re-enabled", 32'(irq_out), 32'b001);

        // R11 level behaviour
        wr(A_SET + 4 * 4, 32'h0);
        wr(A_SET + 4 * 0, 32'h0);
        irq_in[3] = 1'b1;
        tick(4);
        chk("R11 held", 32'(irq_out), 32'b001);
        irq_in[3] = 1'b0;
        tick(2);
        chk("R11 dropped", 32'(irq_out), 0);

        // R10 unmapped access
        rd(A_MST + 4, d); chk("R10 read high", d, 0);
        rd(2, d);         chk("R10 read unaligned", d, 0);
        wr(A_MST + 4, 32'hFFFF_FFFF);
        wr(4 * 4 + 6, 32'hFFFF_FFFF);
        rd(4 + 4 * 4, d); chk("R10 mask kept", d, 32'h8);
        rd(0, d);         chk("R10 chan kept", d, 1);
        rd(A_MDIS, d);    chk("R10 mdis kept", d, 0);

        // R12 save and restore
        irq_in = '0;
        irq_in[64] = 1'b1;
        wr(4 + 4 * 2, 32'h0000_0001);
        wr(4 + 4 * 0, 32'hA5A5_0000);
        tick(2);
        chk("R12 before", 32'(irq_out), 32'b010);
        rd(0, saved_chan);
        for (int j = 0; j < W; j++) begin
            logic [31:0] t;
            rd(4 + 4 * j, t);
            saved[j] = t;
        end
        tick(1);
        rst = 1'b1;
        tick(2);
        rst = 1'b0;
        tick(1);
        chk("R9 after reset out", 32'(irq_out), 0);
        rd(4 + 4 * 2, d); chk("R9 after reset mask", d, 0);
        wr(0, saved_chan);
        for (int j = 0; j < W; j++) wr(4 + 4 * j, saved[j]);
        tick(2);
        chk("R12 restored out", 32'(irq_out), 32'b010);
        rd(4 + 4 * 0, d); chk("R12 restored mask", d, 32'hA5A5_0000);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule